// File: doc/BRIEF.md
# Two-Wire Tuning and Temperature Register Target

This block is a target on a two-wire serial bus (I2C signalling). It answers to one fixed 7-bit device address and exposes four byte-wide registers. Two of them hold a frequency-trim word with a compensation-hold flag. The host can read and write them, and the trim word is presented in parallel on output ports. The other two are read-only and show a 12-bit temperature sample. The sample is captured from a live input at a fixed protocol point, so that a multibyte read of both temperature bytes always returns one coherent value.

SCL and SDA are brought into the system clock through a synchroniser chain. The system clock must run at least 20 times faster than SCL. Edges and bus conditions are found by comparing successive synchronised samples. The block drives SDA only as an open-drain pull-down enable. A write transfer carries the device address, then a register index, then any number of data bytes. A read transfer sends bytes from the current register index until the host declines to acknowledge. The register index advances after every byte in either direction and is kept between transfers.

Top module: `i2c_tune_regs`

## Requirements
- R1: Only the address byte whose upper seven bits equal DEV_ADDR (default 0x41, so 0x82 writes and 0x83 reads) is acknowledged. Any other address gets no acknowledge, and the rest of that transfer drives nothing and changes no register.
- R2: In a write, the first byte after the address loads the 2-bit register index from its two low bits. Each later byte is acknowledged, stored at the index, and then the index is incremented.
- R3: The index wraps from 3 to 0. It keeps its value across STOP. A read that is not preceded by an index byte starts at the kept value.
- R4: Register 0 holds the hold flag in bit 7 and the upper seven trim bits in bits 6:0. Register 1 holds the lower eight trim bits. Both reset to 0x00. comp_hold equals register 0 bit 7, and tune_value equals {register 0 bits 6:0, register 1}.
- R5: Register 2 reads the upper eight bits of the captured temperature. Register 3 reads its lower four bits in bits 7:4, with bits 3:0 zero. The captured value resets to TEMP_RESET (default 0x190).
- R6: The captured temperature is loaded from temp_live only when a matching write address has been followed by an index byte. Reads and later changes of temp_live leave it unchanged.
- R7: Bytes written to registers 2 and 3 are acknowledged and still advance the index, but they change no register.
- R8: tune_commit is a one-cycle pulse raised only when register 1 is written. A write to register 0 gives no pulse.
- R9: In a read, the next byte is sent after each acknowledge from the host. After a not-acknowledge, SDA is released and no more data is driven.
- R10: sda_oe changes only while the synchronised SCL is low. The acknowledge is held for the ninth clock of each accepted byte.
- R11: A START seen in the middle of a transfer drops any partial byte and begins a new address phase.
- R12: After reset and after STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| temp_live | input | TEMP_W (12) | Live temperature code |
| comp_hold | output | 1 | Compensation-hold flag (register 0 bit 7) |
| tune_value | output | 15 | Two's-complement trim word |
| tune_commit | output | 1 | One-cycle pulse when the low trim byte is written |

## Verification
The bench runs a bit-level open-drain host model. It goes after four faults: index wrap at 3, reads that resume from the kept index, temperature writes that must be ignored, and a repeated START that cuts a byte short. A design that lost the index at STOP would send the wrong register in the resumed read. A design that captured temperature on reads would show the later live value. Writing the temperature bytes would leave the test values in the readback, and a design that took a partial byte would miss the following address. A sweep over sixteen trim patterns and all four indexes compares the ports and readback against values computed in the bench. Monitors also count commit pulses and any SDA change made while SCL is high.

// File: rtl/i2c_tune_regs_pkg.sv
package i2c_tune_regs_pkg;
   localparam int PTR_W    = 2;
   localparam int NUM_REGS = 1 << PTR_W;
   localparam int BYTE_W   = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WORD,
      ST_WORD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } bus_state_t;
endpackage

// File: rtl/i2c_tune_sync.sv
module i2c_tune_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic scl_rise,
   output logic scl_fall
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_ff[STAGES-1];
         sda_d  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_tune_engine.sv
module i2c_tune_engine
   import i2c_tune_regs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [PTR_W-1:0]  ptr,
   output logic              wr_en,
   output logic [PTR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              snap_en,
   output logic              sda_oe
);
   bus_state_t        state;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] sh, tx;
   logic              rw, host_nack;
   logic              byte_done;

   assign byte_done = scl_fall && (cnt == 4'd8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sh        <= '0;
         tx        <= '0;
         rw        <= 1'b0;
         host_nack <= 1'b0;
         ptr       <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         snap_en   <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         wr_en   <= 1'b0;
         snap_en <= 1'b0;
         if (start_p) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_p) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WORD, ST_WDATA: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (byte_done) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           rw     <= sh[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_WORD) begin
                        ptr     <= sh[PTR_W-1:0];
                        snap_en <= 1'b1;
                        sda_oe  <= 1'b1;
                        state   <= ST_WORD_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= sh;
                        ptr     <= ptr + 1'b1;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WORD;
                     end
                  end
               end
               ST_WORD_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (byte_done) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 1'b1;
                     cnt    <= '0;
                     state  <= ST_RACK;
                  end else if (scl_fall) begin
                     sda_oe <= ~tx[BYTE_W-2];
                     tx     <= {tx[BYTE_W-2:0], 1'b0};
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_nack <= sda_s;
                  end else if (scl_fall) begin
                     if (!host_nack) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_RDATA;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_tune_regfile.sv
module i2c_tune_regfile
   import i2c_tune_regs_pkg::*;
#(
   parameter int          TEMP_W     = 12,
   parameter int unsigned TEMP_RESET = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              snap_en,
   input  logic [TEMP_W-1:0] temp_live,
   output logic              comp_hold,
   output logic [14:0]       tune_value,
   output logic              tune_commit
);
   localparam int LO_BITS = TEMP_W - BYTE_W;

   logic [BYTE_W-1:0] tune_hi, tune_lo;
   logic [TEMP_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tune_hi     <= '0;
         tune_lo     <= '0;
         snap_q      <= TEMP_W'(TEMP_RESET);
         tune_commit <= 1'b0;
      end else begin
         tune_commit <= 1'b0;
         if (snap_en) snap_q <= temp_live;
         if (wr_en) begin
            case (wr_addr)
               PTR_W'(0): tune_hi <= wr_data;
               PTR_W'(1): begin
                  tune_lo     <= wr_data;
                  tune_commit <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (rd_addr)
         PTR_W'(0): rd_data = tune_hi;
         PTR_W'(1): rd_data = tune_lo;
         PTR_W'(2): rd_data = snap_q[TEMP_W-1 -: BYTE_W];
         default:   rd_data = {snap_q[LO_BITS-1:0], {(BYTE_W-LO_BITS){1'b0}}};
      endcase
   end

   assign comp_hold  = tune_hi[7];
   assign tune_value = {tune_hi[6:0], tune_lo};
endmodule

// File: rtl/i2c_tune_regs.sv
module i2c_tune_regs
   import i2c_tune_regs_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h41,
   parameter int          SYNC_STAGES = 2,
   parameter int          TEMP_W      = 12,
   parameter int unsigned TEMP_RESET  = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [TEMP_W-1:0] temp_live,
   output logic              comp_hold,
   output logic [14:0]       tune_value,
   output logic              tune_commit
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TEMP_W < 9 || TEMP_W > 15) begin : g_bad_temp
      $error("TEMP_W must lie in 9..15");
   end

   logic              scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
   logic [PTR_W-1:0]  ptr, wr_addr;
   logic              wr_en, snap_en;
   logic [BYTE_W-1:0] wr_data, rd_data;

   i2c_tune_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   i2c_tune_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .snap_en(snap_en), .sda_oe(sda_oe)
   );

   i2c_tune_regfile #(.TEMP_W(TEMP_W), .TEMP_RESET(TEMP_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
      .snap_en(snap_en), .temp_live(temp_live), .comp_hold(comp_hold),
      .tune_value(tune_value), .tune_commit(tune_commit)
   );
endmodule

// File: rtl/i2c_tune_regs_chk.sv
module i2c_tune_regs_chk #(
   parameter int PTR_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             sda_oe,
   input logic             wr_en,
   input logic [PTR_W-1:0] wr_addr,
   input logic [PTR_W-1:0] ptr,
   input logic             comp_hold,
   input logic [14:0]      tune_value,
   input logic             tune_commit
);
   a_r8_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tune_commit |=> !tune_commit);

   a_r8_commit_source: assert property (@(posedge clk) disable iff (!rst_n)
      tune_commit |-> ($past(wr_en) && $past(wr_addr) == PTR_W'(1)));

   a_r7_tune_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({comp_hold, tune_value}));

   a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr == PTR_W'(wr_addr + 1'b1)));
endmodule

bind i2c_tune_regs i2c_tune_regs_chk #(.PTR_W(i2c_tune_regs_pkg::PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr), .comp_hold(comp_hold),
   .tune_value(tune_value), .tune_commit(tune_commit)
);

// File: tb/tb_i2c_tune_regs.sv
module tb_i2c_tune_regs;
   localparam int QTR = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1, m_sda = 1'b1;
   logic        sda_oe, comp_hold, tune_commit;
   logic [11:0] temp_live = 12'h000;
   logic [14:0] tune_value;
   wire         sda_bus = m_sda & ~sda_oe;

   int tests = 0, fails = 0;
   int commit_cnt = 0, commit_wide = 0, scl_high_chg = 0;
   logic prev_commit = 1'b0, prev_oe = 1'b0;
   logic [7:0] model [4];

   always #2.5 clk = ~clk;

   i2c_tune_regs dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .temp_live(temp_live), .comp_hold(comp_hold),
      .tune_value(tune_value), .tune_commit(tune_commit)
   );

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (tune_commit) commit_cnt++;
         if (tune_commit && prev_commit) commit_wide++;
         if (sda_oe != prev_oe && m_scl) scl_high_chg++;
      end
      prev_commit = tune_commit;
      prev_oe     = sda_oe;
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b0; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      m_sda = 1'b1; qwait();
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; qwait();
      m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; qwait();
      m_scl = 1'b1; qwait();
      b = sda_bus; qwait();
      m_scl = 1'b0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~give_ack);
   endtask

   task automatic write_regs(input logic [1:0] idx, input logic [7:0] d0,
                             input logic [7:0] d1, input int n, input string tag);
      logic a;
      bus_start();
      send_byte(8'h82, a); chk({tag, " addr ack"}, a, 1);
      send_byte({6'd0, idx}, a); chk({tag, " index ack"}, a, 1);
      if (n > 0) begin send_byte(d0, a); chk({tag, " data0 ack"}, a, 1); end
      if (n > 1) begin send_byte(d1, a); chk({tag, " data1 ack"}, a, 1); end
      bus_stop();
   endtask

   task automatic read_at(input logic [1:0] idx, output logic [7:0] v);
      logic a;
      bus_start();
      send_byte(8'h82, a);
      send_byte({6'd0, idx}, a);
      bus_start();
      send_byte(8'h83, a);
      recv_byte(v, 1'b0);
      bus_stop();
   endtask

   initial begin
      repeat (QTR * 3000 * 6) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] v;
      int c0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R12 / R4: reset state
      chk("R12 sda released at reset", sda_oe, 0);
      chk("R4 comp_hold reset", comp_hold, 0);
      chk("R4 tune_value reset", tune_value, 0);

      // R1, R5, R9: read four bytes from reset index
      bus_start();
      send_byte(8'h83, a); chk("R1 read address acked", a, 1);
      recv_byte(v, 1'b1); chk("R4 reg0 reset", v, 8'h00);
      recv_byte(v, 1'b1); chk("R4 reg1 reset", v, 8'h00);
      recv_byte(v, 1'b1); chk("R5 reg2 reset temp", v, 8'h19);
      recv_byte(v, 1'b0); chk("R5 reg3 reset temp", v, 8'h00);
      qwait();
      chk("R9 sda released after nack", sda_oe, 0);
      bus_stop();
      chk("R12 sda released after stop", sda_oe, 0);

      // R1: foreign addresses
      bus_start();
      send_byte(8'h84, a); chk("R1 foreign write address not acked", a, 0);
      send_byte(8'h00, a); chk("R1 byte after foreign address not acked", a, 0);
      send_byte(8'hFF, a);
      bus_stop();
      chk("R1 foreign write no effect", {comp_hold, tune_value}, 0);
      bus_start();
      send_byte(8'h85, a); chk("R1 foreign read address not acked", a, 0);
      recv_byte(v, 1'b0); chk("R1 foreign read drives nothing", v, 8'hFF);
      bus_stop();

      // R2, R4, R6, R8: write both trim bytes
      temp_live = 12'h5A7;
      c0 = commit_cnt;
      bus_start();
      send_byte(8'h82, a); chk("R2 write address ack", a, 1);
      send_byte(8'h00, a); chk("R2 index ack", a, 1);
      send_byte(8'hC5, a); chk("R2 data ack", a, 1);
      chk("R8 no commit on reg0 write", commit_cnt - c0, 0);
      send_byte(8'hA3, a); chk("R2 data ack", a, 1);
      bus_stop();
      chk("R8 one commit on reg1 write", commit_cnt - c0, 1);
      chk("R4 comp_hold from bit7", comp_hold, 1);
      chk("R4 tune_value", tune_value, 15'h45A3);

      // R3, R6: resume read from kept index 2, wrap to 0
      temp_live = 12'hFFF;
      bus_start();
      send_byte(8'h83, a);
      recv_byte(v, 1'b1); chk("R6 reg2 holds captured temp", v, 8'h5A);
      recv_byte(v, 1'b1); chk("R6 reg3 holds captured temp", v, 8'h70);
      recv_byte(v, 1'b1); chk("R3 index wraps to reg0", v, 8'hC5);
      recv_byte(v, 1'b0); chk("R3 reg1 after wrap", v, 8'hA3);
      bus_stop();

      // R7: temperature writes ignored
      c0 = commit_cnt;
      write_regs(2'd2, 8'h11, 8'h22, 2, "R7");
      chk("R7 trim unchanged", tune_value, 15'h45A3);
      chk("R7 no commit", commit_cnt - c0, 0);
      temp_live = 12'h123;
      bus_start();
      send_byte(8'h82, a);
      send_byte(8'h02, a);
      bus_start();
      send_byte(8'h83, a); chk("R11 read after repeated start acked", a, 1);
      recv_byte(v, 1'b1); chk("R7 reg2 not written, R6 fresh capture", v, 8'h12);
      recv_byte(v, 1'b0); chk("R7 reg3 not written, R5 low nibble zero", v, 8'h30);
      bus_stop();

      // R3: write wraps from 3 to 0
      c0 = commit_cnt;
      bus_start();
      send_byte(8'h82, a);
      send_byte(8'h03, a);
      send_byte(8'h33, a); chk("R7 reg3 write acked", a, 1);
      send_byte(8'h44, a);
      send_byte(8'h55, a);
      bus_stop();
      chk("R3 write wraps into reg0/reg1", tune_value, 15'h4455);
      chk("R3 comp_hold after wrap", comp_hold, 0);
      chk("R8 commit after wrap", commit_cnt - c0, 1);

      // R11: START cuts a partial byte
      bus_start();
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
      bus_start();
      send_byte(8'h82, a); chk("R11 address after abort acked", a, 1);
      send_byte(8'h01, a);
      send_byte(8'h66, a);
      bus_stop();
      chk("R11 write after abort", tune_value, 15'h4466);

      // R2, R4: sweep trim patterns
      for (int i = 0; i < 16; i++) begin
         logic [15:0] p;
         logic [7:0] rh, rl;
         p = 16'(i * 16'h1357) ^ 16'(i << 9);
         write_regs(2'd0, p[15:8], p[7:0], 2, "R2 sweep");
         chk("R4 sweep comp_hold", comp_hold, int'(p[15]));
         chk("R4 sweep tune_value", tune_value, int'(p[14:0]));
         bus_start();
         send_byte(8'h82, a); send_byte(8'h00, a);
         bus_start();
         send_byte(8'h83, a);
         recv_byte(rh, 1'b1); recv_byte(rl, 1'b0);
         bus_stop();
         chk("R2 sweep readback hi", rh, int'(p[15:8]));
         chk("R2 sweep readback lo", rl, int'(p[7:0]));
         model[0] = p[15:8];
         model[1] = p[7:0];
      end

      // R3: each index
      model[2] = 8'h12;
      model[3] = 8'h30;
      for (int w = 0; w < 4; w++) begin
         read_at(2'(w), v);
         chk("R3 index select", v, int'(model[w]));
      end

      chk("R8 commit width one cycle", commit_wide, 0);
      chk("R10 no SDA change while SCL high", scl_high_chg, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule